// File: doc/BRIEF.md
# Serial Port Configuration Register Bank

This block is the software-visible register file that sits in front of a serial port engine. A simple word-addressed bus (one write strobe, one read strobe, byte address, 32-bit write and read data) reaches three configuration registers: line mode, control/status, and baud divisor. Each configuration register can be reached at four addresses. The first is its plain location. The other three apply a clear, set or toggle of the bits selected by the write data. Software can therefore change a single field without reading the register first. Reads at any of the four addresses return the register's current value.

Two further locations act as the data path to the engine. A write to the transmit port hands a 9-bit character to the engine with a one-cycle push pulse. A read of the receive port returns the engine's current 9-bit character and issues a one-cycle pop pulse. Line events reported by the engine appear as read-only status bits. The one exception is the overrun flag: hardware latches it and software clears it.

Top module: `sercfg_regbank`

## Requirements
- R1: After reset every register reads zero, and `tx_push`, `rx_pop`, `tx_char` and `bus_rdata` are zero.
- R2: A write to the mode register at offset 0x00 stores the write data ANDed with the implemented mask 0x0000_BBFF. Bits 10 and 14 and bits 31:16 always read zero.
- R3: A write to base+0x04 of a configuration register (bases 0x00, 0x10, 0x40) clears every bit where the write data is 1 and leaves the other bits unchanged.
- R4: A write to base+0x08 sets every implemented bit where the write data is 1 and leaves the other bits unchanged.
- R5: A write to base+0x0C toggles every implemented bit where the write data is 1 and leaves the other bits unchanged.
- R6: A read at base+0x04, base+0x08 or base+0x0C returns the same value as a read at the base, and it changes nothing.
- R7: The writable bits of the status register at 0x10 are those in mask 0x01FF_FCE0. These include the address-match field at bits 23:16 and the match enable at bit 24. Bits 0 (data available), 2 (framing), 3 (parity), 4 (line idle), 8 (shifter empty) and 9 (transmit full) show the corresponding inputs, and no write changes them.
- R8: Status bit 1 (overrun) is set one cycle after a cycle with `hw_overrun` high and then stays set. It is cleared by a base write with bit 1 at 0 or by a clear-alias write with bit 1 at 1. Set-alias and invert-alias writes, and base writes with bit 1 at 1, leave it unchanged. A hardware event in the same cycle as a clear wins.
- R9: The baud divisor at 0x40 holds 16 bits. Bits 31:16 are ignored on write and read as zero.
- R10: A write to 0x20 makes `tx_push` high for exactly the next cycle, with `tx_char` equal to write data bits 8:0. A read of 0x20 returns zero.
- R11: A read of 0x30 returns `rx_char` zero-extended, and `rx_pop` is high for exactly the next cycle.
- R12: Read data is registered. It takes its new value at the clock edge where `bus_rd` is high and holds it until the next read. Addresses that are not mapped (including 0x24 to 0x2C, 0x34 to 0x3C, and 0x50 and above) read zero, and writes to them have no effect and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_rx_avail | input | 1 | Engine has a received character |
| hw_overrun | input | 1 | Receive overrun event pulse |
| hw_frame_err | input | 1 | Framing error on current character |
| hw_parity_err | input | 1 | Parity error on current character |
| hw_rx_idle | input | 1 | Receive line idle |
| hw_tx_empty | input | 1 | Transmit shifter empty |
| hw_tx_full | input | 1 | Transmit buffer full |
| rx_char | input | 9 | Character at the head of the receive path |
| mode_q | output | 32 | Current mode register |
| stat_q | output | 32 | Current status view, including hardware bits |
| baud_q | output | 16 | Current baud divisor |
| tx_push | output | 1 | One-cycle transmit push pulse |
| tx_char | output | 9 | Character for the transmit path |
| rx_pop | output | 1 | One-cycle receive pop pulse |

## Verification
Each result of this block lands one clock edge after its stimulus. Register contents, the overrun flag, read data and both pulses all change at the edge where the strobe or event input is high. The bench drives every strobe on a falling edge and drops it on the next falling edge. It samples the outputs at that second falling edge, half a cycle after the edge that acted. To show that a pulse lasts exactly one cycle, the bench samples again one full cycle later and expects it low. Checks that a write had no effect read the register back through the bus afterwards.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
   typedef enum logic [1:0] {
      OP_WR  = 2'd0,
      OP_CLR = 2'd1,
      OP_SET = 2'd2,
      OP_INV = 2'd3
   } alias_op_e;

   typedef enum logic [2:0] {
      G_MODE = 3'd0,
      G_STAT = 3'd1,
      G_TXD  = 3'd2,
      G_RXD  = 3'd3,
      G_BAUD = 3'd4,
      G_NONE = 3'd7
   } reg_grp_e;

   localparam int ST_AVAIL  = 0;
   localparam int ST_OVR    = 1;
   localparam int ST_FRAME  = 2;
   localparam int ST_PARITY = 3;
   localparam int ST_IDLE   = 4;
   localparam int ST_EMPTY  = 8;
   localparam int ST_FULL   = 9;
   localparam int ST_TOP    = 24;
endpackage

// File: rtl/sercfg_addr_dec.sv
module sercfg_addr_dec
   import sercfg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_grp_e          grp,
   output alias_op_e         op
);
   initial begin
      if (ADDR_W < 8) $error("sercfg_addr_dec: ADDR_W must be at least 8");
   end

   always_comb begin
      op  = alias_op_e'(addr[3:2]);
      grp = G_NONE;
      if (addr[ADDR_W-1:7] == '0) begin
         case (addr[6:4])
            3'd0:    grp = G_MODE;
            3'd1:    grp = G_STAT;
            3'd2:    grp = (addr[3:2] == 2'd0) ? G_TXD : G_NONE;
            3'd3:    grp = (addr[3:2] == 2'd0) ? G_RXD : G_NONE;
            3'd4:    grp = G_BAUD;
            default: grp = G_NONE;
         endcase
      end
   end
endmodule

// File: rtl/sercfg_alias_reg.sv
module sercfg_alias_reg
   import sercfg_pkg::*;
#(
   parameter int           W    = 32,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  alias_op_e    op,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);
   logic [W-1:0] sel;
   logic [W-1:0] nxt;

   assign sel = wd & MASK;

   always_comb begin
      case (op)
         OP_WR:   nxt = sel;
         OP_CLR:  nxt = q & ~wd;
         OP_SET:  nxt = q | sel;
         default: nxt = q ^ sel;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= nxt;
   end
endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank
   import sercfg_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 32,
   parameter int                CHAR_W    = 9,
   parameter int                BAUD_W    = 16,
   parameter bit                READ_REG  = 1'b1,
   parameter logic [DATA_W-1:0] MODE_MASK = 32'h0000_BBFF,
   parameter logic [DATA_W-1:0] STAT_MASK = 32'h01FF_FCE0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              hw_rx_avail,
   input  logic              hw_overrun,
   input  logic              hw_frame_err,
   input  logic              hw_parity_err,
   input  logic              hw_rx_idle,
   input  logic              hw_tx_empty,
   input  logic              hw_tx_full,
   input  logic [CHAR_W-1:0] rx_char,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] stat_q,
   output logic [BAUD_W-1:0] baud_q,
   output logic              tx_push,
   output logic [CHAR_W-1:0] tx_char,
   output logic              rx_pop
);
   localparam logic [DATA_W-1:0] HW_BITS =
      DATA_W'((1 << ST_AVAIL) | (1 << ST_FRAME) | (1 << ST_PARITY) |
              (1 << ST_IDLE) | (1 << ST_EMPTY) | (1 << ST_FULL) | (1 << ST_OVR));
   localparam logic [DATA_W-1:0] STAT_SW = STAT_MASK & ~HW_BITS;

   initial begin
      if (DATA_W <= ST_TOP)  $error("sercfg_regbank: DATA_W too small for status field");
      if (CHAR_W > DATA_W)   $error("sercfg_regbank: CHAR_W exceeds DATA_W");
      if (BAUD_W > DATA_W)   $error("sercfg_regbank: BAUD_W exceeds DATA_W");
   end

   reg_grp_e  grp;
   alias_op_e op;
   logic      ovr_q;
   logic [DATA_W-1:0] ctl_q;
   logic [DATA_W-1:0] hw_vec;
   logic [DATA_W-1:0] rd_mux;

   sercfg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .grp(grp), .op(op)
   );

   sercfg_alias_reg #(.W(DATA_W), .MASK(MODE_MASK)) u_mode (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && grp == G_MODE),
      .op(op), .wd(bus_wdata), .q(mode_q)
   );

   sercfg_alias_reg #(.W(DATA_W), .MASK(STAT_SW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && grp == G_STAT),
      .op(op), .wd(bus_wdata), .q(ctl_q)
   );

   sercfg_alias_reg #(.W(BAUD_W), .MASK({BAUD_W{1'b1}})) u_baud (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && grp == G_BAUD),
      .op(op), .wd(bus_wdata[BAUD_W-1:0]), .q(baud_q)
   );

   // Overrun is latched by hardware and can only be cleared by software.
   logic ovr_sw_clr;
   assign ovr_sw_clr = bus_wr && grp == G_STAT &&
                       ((op == OP_WR  && !bus_wdata[ST_OVR]) ||
                        (op == OP_CLR &&  bus_wdata[ST_OVR]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ovr_q <= 1'b0;
      else if (hw_overrun) ovr_q <= 1'b1;
      else if (ovr_sw_clr) ovr_q <= 1'b0;
   end

   always_comb begin
      hw_vec            = '0;
      hw_vec[ST_AVAIL]  = hw_rx_avail;
      hw_vec[ST_OVR]    = ovr_q;
      hw_vec[ST_FRAME]  = hw_frame_err;
      hw_vec[ST_PARITY] = hw_parity_err;
      hw_vec[ST_IDLE]   = hw_rx_idle;
      hw_vec[ST_EMPTY]  = hw_tx_empty;
      hw_vec[ST_FULL]   = hw_tx_full;
   end

   assign stat_q = ctl_q | hw_vec;

   always_comb begin
      case (grp)
         G_MODE:  rd_mux = mode_q;
         G_STAT:  rd_mux = stat_q;
         G_BAUD:  rd_mux = DATA_W'(baud_q);
         G_RXD:   rd_mux = DATA_W'(rx_char);
         default: rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rdata_q <= '0;
            else if (bus_rd) rdata_q <= rd_mux;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? rd_mux : '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_push <= 1'b0;
         tx_char <= '0;
         rx_pop  <= 1'b0;
      end else begin
         tx_push <= bus_wr && grp == G_TXD;
         rx_pop  <= bus_rd && grp == G_RXD;
         if (bus_wr && grp == G_TXD) tx_char <= bus_wdata[CHAR_W-1:0];
      end
   end
endmodule

// File: rtl/sercfg_regbank_chk.sv
module sercfg_regbank_chk #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 32,
   parameter int                CHAR_W    = 9,
   parameter int                BAUD_W    = 16,
   parameter logic [DATA_W-1:0] MODE_MASK = 32'h0000_BBFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              hw_rx_avail,
   input logic              hw_overrun,
   input logic              hw_frame_err,
   input logic              hw_parity_err,
   input logic              hw_rx_idle,
   input logic              hw_tx_empty,
   input logic              hw_tx_full,
   input logic [CHAR_W-1:0] rx_char,
   input logic [DATA_W-1:0] mode_q,
   input logic [DATA_W-1:0] stat_q,
   input logic [BAUD_W-1:0] baud_q,
   input logic              tx_push,
   input logic [CHAR_W-1:0] tx_char,
   input logic              rx_pop
);
   localparam logic [ADDR_W-1:0] A_MODE_CLR = ADDR_W'(8'h04);
   localparam logic [ADDR_W-1:0] A_MODE_SET = ADDR_W'(8'h08);
   localparam logic [ADDR_W-1:0] A_TXD      = ADDR_W'(8'h20);
   localparam logic [ADDR_W-1:0] A_RXD      = ADDR_W'(8'h30);

   assert_mode_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q & ~MODE_MASK) == '0);

   assert_mode_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[ADDR_W-1:2] == A_MODE_CLR[ADDR_W-1:2])
      |=> mode_q == ($past(mode_q) & ~$past(bus_wdata)));

   assert_mode_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[ADDR_W-1:2] == A_MODE_SET[ADDR_W-1:2])
      |=> mode_q == ($past(mode_q) | ($past(bus_wdata) & MODE_MASK)));

   assert_ovr_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hw_overrun |=> stat_q[1]);

   assert_ovr_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[1]) |-> $past(hw_overrun));

   assert_push_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[ADDR_W-1:2] == A_TXD[ADDR_W-1:2]) |=> tx_push);

   assert_push_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> $past(bus_wr));

   assert_pop_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[ADDR_W-1:2] == A_RXD[ADDR_W-1:2]) |=> rx_pop);

   assert_pop_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> $past(bus_rd));
endmodule

bind sercfg_regbank sercfg_regbank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
   .BAUD_W(BAUD_W), .MODE_MASK(MODE_MASK)
) u_chk (.*);

// File: tb/sercfg_regbank_bench.sv
`timescale 1ns/1ps
module sercfg_regbank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        hw_rx_avail = 0, hw_overrun = 0, hw_frame_err = 0, hw_parity_err = 0;
   logic        hw_rx_idle = 0, hw_tx_empty = 0, hw_tx_full = 0;
   logic [8:0]  rx_char = '0;
   logic [31:0] mode_q, stat_q;
   logic [15:0] baud_q;
   logic        tx_push, rx_pop;
   logic [8:0]  tx_char;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   sercfg_regbank u_sercfg_regbank (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 push", {31'b0, tx_push}, 0);
      check("R1 pop", {31'b0, rx_pop}, 0);
      rd(8'h00, d); check("R1 mode", d, 0);
      rd(8'h10, d); check("R1 stat", d, 0);
      rd(8'h40, d); check("R1 baud", d, 0);
   endtask

   task automatic t_mode();
      logic [31:0] d;
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 mask", d, 32'h0000_BBFF);
      wr(8'h00, 32'h0000_00F0);
      wr(8'h04, 32'hFFFF_0030); rd(8'h00, d); check("R3 clear", d, 32'h0000_00C0);
      wr(8'h08, 32'hFFFF_4101); rd(8'h00, d); check("R4 set", d, 32'h0000_01C1);
      wr(8'h0C, 32'h0000_C441); rd(8'h00, d); check("R5 invert", d, 32'h0000_8180);
      rd(8'h04, d); check("R6 clr alias read", d, 32'h0000_8180);
      rd(8'h08, d); check("R6 set alias read", d, 32'h0000_8180);
      rd(8'h0C, d); check("R6 inv alias read", d, 32'h0000_8180);
      rd(8'h00, d); check("R6 base unchanged", d, 32'h0000_8180);
   endtask

   task automatic t_status();
      logic [31:0] d;
      @(negedge clk);
      hw_rx_avail = 1; hw_frame_err = 1; hw_rx_idle = 1; hw_tx_full = 1;
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); check("R7 full write", d, 32'h01FF_FEF5);
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h10, d); check("R7 hw bits survive", d, 32'h0000_0215);
      wr(8'h18, 32'h01AB_0000); rd(8'h1C, d); check("R7 match field", d, 32'h01AB_0215);
      @(negedge clk);
      hw_rx_avail = 0; hw_frame_err = 0; hw_rx_idle = 0; hw_tx_full = 0;
      hw_parity_err = 1; hw_tx_empty = 1;
      rd(8'h10, d); check("R7 hw follow", d, 32'h01AB_0108);
      wr(8'h10, 32'h0);
      @(negedge clk); hw_parity_err = 0; hw_tx_empty = 0;
   endtask

   task automatic pulse_ovr();
      @(negedge clk); hw_overrun = 1;
      @(negedge clk); hw_overrun = 0;
   endtask

   task automatic t_overrun();
      logic [31:0] d;
      pulse_ovr();
      check("R8 stat_q set", stat_q, 32'h2);
      wr(8'h10, 32'h2);  rd(8'h10, d); check("R8 base write 1 keeps", d, 32'h2);
      wr(8'h0C + 8'h10, 32'h2); rd(8'h10, d); check("R8 invert keeps", d, 32'h2);
      wr(8'h10, 32'h0);  rd(8'h10, d); check("R8 base write 0 clears", d, 32'h0);
      wr(8'h18, 32'h2);  rd(8'h10, d); check("R8 set cannot set", d, 32'h0);
      pulse_ovr();
      wr(8'h14, 32'h2);  rd(8'h10, d); check("R8 clear alias", d, 32'h0);
      // hardware event in the same cycle as a clear wins
      @(negedge clk); hw_overrun = 1; bus_wr = 1; bus_addr = 8'h14; bus_wdata = 32'h2;
      @(negedge clk); hw_overrun = 0; bus_wr = 0;
      check("R8 hw wins", stat_q, 32'h2);
      wr(8'h10, 32'h0);
   endtask

   task automatic t_baud();
      logic [31:0] d;
      wr(8'h40, 32'h1234_ABCD); rd(8'h40, d); check("R9 low16", d, 32'h0000_ABCD);
      wr(8'h4C, 32'hFFFF_FFFF); rd(8'h44, d); check("R5 baud invert", d, 32'h0000_5432);
      wr(8'h48, 32'hFFFF_0000); rd(8'h40, d); check("R9 set upper ignored", d, 32'h0000_5432);
      check("R9 baud_q", {16'h0, baud_q}, 32'h0000_5432);
   endtask

   task automatic t_tx();
      logic [31:0] d;
      wr(8'h20, 32'hFFFF_F1A5);
      check("R10 push high", {31'b0, tx_push}, 1);
      check("R10 char", {23'b0, tx_char}, 32'h1A5);
      @(negedge clk);
      check("R10 push one cycle", {31'b0, tx_push}, 0);
      rd(8'h20, d); check("R10 read zero", d, 0);
   endtask

   task automatic t_rx();
      @(negedge clk); rx_char = 9'h1C3; bus_rd = 1; bus_addr = 8'h30;
      @(negedge clk); bus_rd = 0;
      check("R11 data", bus_rdata, 32'h0000_01C3);
      check("R11 pop high", {31'b0, rx_pop}, 1);
      @(negedge clk);
      check("R11 pop one cycle", {31'b0, rx_pop}, 0);
      check("R12 rdata held", bus_rdata, 32'h0000_01C3);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(8'h24, 32'h1FF);
      check("R12 no push on 0x24", {31'b0, tx_push}, 0);
      wr(8'h50, 32'hFFFF);
      rd(8'h50, d); check("R12 unmapped read", d, 0);
      rd(8'h34, d); check("R12 no pop data", d, 0);
      check("R12 no pop on 0x34", {31'b0, rx_pop}, 0);
      rd(8'h40, d); check("R12 baud untouched", d, 32'h0000_5432);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode();
      t_status();
      t_overrun();
      t_baud();
      t_tx();
      t_rx();
      t_unmapped();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule